// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block watches the supply of a battery-backed byte-wide memory and decides when the memory may be accessed. Two external comparators report, as asynchronous digital flags, that the supply is under the deselect threshold and that it is under the lower battery switchover threshold. The block resynchronizes and debounces both flags. It then steps through a small sequence of states and drives a protect signal, a battery-select signal and a 3-bit status code. All of this runs on a free-running clock, and every time window is a cycle count set by a parameter.

The host's chip, output and write enables pass through the block to the memory. While protection is on, the block holds all three memory strobes inactive and turns off the data output drive, whatever the host does. If a supply drop is seen while the host already has chip enable active, that access may continue. Protection waits until the access ends or until a bounded window runs out, whichever comes first. When the supply returns, protection stays on for a full recovery period before access is allowed again. Coming out of reset counts as a return of supply, so the block also starts protected and passes through a recovery period.

Top module: `pfs_sequencer`

## Requirements
- R1: Status codes are 0 normal, 1 pending-protect, 2 protected, 3 battery, 4 recovering. During reset the status is 4 and protect is 1. After reset is released with both flags low, the status becomes 0 exactly ER_CYCLES clock cycles later.
- R2: Each supply flag passes through two synchronizing flops and then needs DEBOUNCE consecutive equal samples before it takes effect. A pulse shorter than DEBOUNCE cycles leaves the status at 0 and protect at 0.
- R3: If the deselect flag rises while host_ce_n is high, protect rises and the status becomes 2 within DEBOUNCE+3 cycles of the flag change.
- R4: If the deselect flag rises while host_ce_n is low, the status becomes 1 and protect stays 0, so host strobes still pass to the memory. One cycle after host_ce_n returns high, the status becomes 2.
- R5: If an access in the pending state never ends, the status becomes 2 exactly WP_CYCLES cycles after it entered 1.
- R6: While protect is 1, mem_ce_n, mem_oe_n and mem_we_n are all 1 and dq_drive_en is 0, whatever the host strobes are.
- R7: When the switchover flag is active, the status is 3 and battery_sel is 1. When that flag clears, battery_sel returns to 0 and the status returns to 2.
- R8: If the switchover flag takes effect during the pending state, the status goes straight to 3 and protect rises, without waiting for the access window.
- R9: After the deselect flag clears, the status is 4 for exactly ER_CYCLES cycles and then becomes 0. If the deselect flag returns during recovery, the status goes back to 2 and the full recovery period starts again.
- R10: In normal state, dq_drive_en is 1 exactly when host_ce_n and host_oe_n are low and host_we_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlow_desel_i | input | 1 | Async flag: supply below deselect threshold |
| vlow_batt_i | input | 1 | Async flag: supply below switchover threshold |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to memory |
| mem_oe_n | output | 1 | Gated output enable to memory |
| mem_we_n | output | 1 | Gated write enable to memory |
| dq_drive_en | output | 1 | Data bus drive enable; 0 means high-Z |
| protect | output | 1 | Write-protect / deselect active |
| battery_sel | output | 1 | Select the backup battery |
| status | output | 3 | Sequencer state code |

## Verification
Some properties are checked on every cycle. Protect forces every memory strobe inactive and the data drive off. Battery select never appears without protect. In the pending state the host strobes pass through unchanged. No pending stay lasts longer than WP_CYCLES. Every exit to normal follows exactly ER_CYCLES cycles of recovery.

Other behaviour can only be shown by the bench's scenarios. These include the latency from an asynchronous flag change, the filtering of short glitches, and the end of an access releasing the pending state. They also include the battery state being entered and left, and an interrupted recovery restarting.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_PENDING = 3'd1,
        ST_PROT    = 3'd2,
        ST_BATT    = 3'd3,
        ST_RECOVER = 3'd4
    } pfs_state_e;

    localparam int unsigned FLAG_DESEL = 0;
    localparam int unsigned FLAG_BATT  = 1;
    localparam int unsigned NUM_FLAGS  = 2;

endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter #(
    parameter int unsigned DEBOUNCE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);
    localparam int unsigned DW = $clog2(DEBOUNCE + 1);
    localparam logic [DW-1:0] LAST = DW'(DEBOUNCE - 1);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          flag;
        logic [DW-1:0] run;
    } flt_t;

    flt_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = raw_i;
        r_d.sync = r_q.meta;
        if (r_q.sync == r_q.flag) begin
            r_d.run = '0;
        end else if (r_q.run == LAST) begin
            r_d.flag = r_q.sync;
            r_d.run  = '0;
        end else begin
            r_d.run = r_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_o = r_q.flag;
endmodule

// File: rtl/pfs_port_gate.sv
module pfs_port_gate (
    input  logic protect_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    output logic ce_n_o,
    output logic oe_n_o,
    output logic we_n_o,
    output logic drive_o
);
    always_comb begin
        ce_n_o  = protect_i | ce_n_i;
        oe_n_o  = protect_i | oe_n_i;
        we_n_o  = protect_i | we_n_i;
        drive_o = !protect_i && !ce_n_i && !oe_n_i && we_n_i;
    end
endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer #(
    parameter int unsigned DEBOUNCE   = 4,
    parameter int unsigned WP_CYCLES  = 64,
    parameter int unsigned ER_CYCLES  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vlow_desel_i,
    input  logic       vlow_batt_i,
    input  logic       host_ce_n,
    input  logic       host_oe_n,
    input  logic       host_we_n,
    output logic       mem_ce_n,
    output logic       mem_oe_n,
    output logic       mem_we_n,
    output logic       dq_drive_en,
    output logic       protect,
    output logic       battery_sel,
    output logic [2:0] status
);
    import pfs_pkg::*;

    localparam int unsigned MAXW = (WP_CYCLES > ER_CYCLES) ? WP_CYCLES : ER_CYCLES;
    localparam int unsigned CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] WP_LAST = CW'(WP_CYCLES - 1);
    localparam logic [CW-1:0] ER_LAST = CW'(ER_CYCLES - 1);

    typedef struct packed {
        pfs_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    logic [NUM_FLAGS-1:0] raw_flags, flt_flags;
    assign raw_flags[FLAG_DESEL] = vlow_desel_i;
    assign raw_flags[FLAG_BATT]  = vlow_batt_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
        pfs_flag_filter #(.DEBOUNCE(DEBOUNCE)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .flag_o (flt_flags[g])
        );
    end

    logic desel_f, batt_f, busy;
    assign desel_f = flt_flags[FLAG_DESEL];
    assign batt_f  = flt_flags[FLAG_BATT];
    assign busy    = !host_ce_n;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = '0;
        unique case (s_q.st)
            ST_NORMAL: begin
                if (batt_f)       s_d.st = ST_BATT;
                else if (desel_f) s_d.st = busy ? ST_PENDING : ST_PROT;
            end
            ST_PENDING: begin
                if (batt_f)                       s_d.st = ST_BATT;
                else if (!busy || s_q.cnt == WP_LAST) s_d.st = ST_PROT;
                else                              s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_PROT: begin
                if (batt_f)        s_d.st = ST_BATT;
                else if (!desel_f) s_d.st = ST_RECOVER;
            end
            ST_BATT: begin
                if (!batt_f) s_d.st = ST_PROT;
            end
            ST_RECOVER: begin
                if (batt_f)                 s_d.st = ST_BATT;
                else if (desel_f)           s_d.st = ST_PROT;
                else if (s_q.cnt == ER_LAST) s_d.st = ST_NORMAL;
                else                        s_d.cnt = s_q.cnt + 1'b1;
            end
            default: s_d.st = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_RECOVER;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign protect     = (s_q.st != ST_NORMAL) && (s_q.st != ST_PENDING);
    assign battery_sel = (s_q.st == ST_BATT);
    assign status      = s_q.st;

    pfs_port_gate u_gate (
        .protect_i (protect),
        .ce_n_i    (host_ce_n),
        .oe_n_i    (host_oe_n),
        .we_n_i    (host_we_n),
        .ce_n_o    (mem_ce_n),
        .oe_n_o    (mem_oe_n),
        .we_n_o    (mem_we_n),
        .drive_o   (dq_drive_en)
    );
endmodule

// File: rtl/pfs_sequencer_chk.sv
module pfs_sequencer_chk #(
    parameter int unsigned WP_CYCLES = 64,
    parameter int unsigned ER_CYCLES = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ce_n,
    input logic       host_oe_n,
    input logic       host_we_n,
    input logic       mem_ce_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       dq_drive_en,
    input logic       protect,
    input logic       battery_sel,
    input logic [2:0] status
);
    int unsigned pend_run, rec_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_run <= 0;
            rec_run  <= 0;
        end else begin
            pend_run <= (status == 3'd1) ? pend_run + 1 : 0;
            rec_run  <= (status == 3'd4) ? rec_run + 1 : 0;
        end
    end

    AST_PROT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_drive_en)); // R6
    AST_BATT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        battery_sel |-> (protect && status == 3'd3)); // R7
    AST_PEND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1) |-> (!protect && mem_ce_n == host_ce_n && mem_we_n == host_we_n
                              && mem_oe_n == host_oe_n)); // R4
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1) |-> (pend_run < WP_CYCLES)); // R5
    AST_RECOVER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && $past(status) == 3'd4) |-> (rec_run == ER_CYCLES)); // R9
    AST_NORMAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0) |-> (dq_drive_en == (!host_ce_n && !host_oe_n && host_we_n))); // R10
endmodule

bind pfs_sequencer pfs_sequencer_chk #(
    .WP_CYCLES (WP_CYCLES),
    .ER_CYCLES (ER_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ce_n   (host_ce_n),
    .host_oe_n   (host_oe_n),
    .host_we_n   (host_we_n),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .dq_drive_en (dq_drive_en),
    .protect     (protect),
    .battery_sel (battery_sel),
    .status      (status)
);

// File: tb/pfs_sequencer_test.sv
`timescale 1ns/1ps
module pfs_sequencer_test;
    localparam int DB = 4;
    localparam int WP = 30;
    localparam int ER = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desel = 1'b0, batt = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic mce_n, moe_n, mwe_n, drv, prot, bsel;
    logic [2:0] status;
    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    pfs_sequencer #(.DEBOUNCE(DB), .WP_CYCLES(WP), .ER_CYCLES(ER)) uut (
        .clk(clk), .rst_n(rst_n), .vlow_desel_i(desel), .vlow_batt_i(batt),
        .host_ce_n(ce_n), .host_oe_n(oe_n), .host_we_n(we_n),
        .mem_ce_n(mce_n), .mem_oe_n(moe_n), .mem_we_n(mwe_n),
        .dq_drive_en(drv), .protect(prot), .battery_sel(bsel), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        compared++;
        if (act < lo || act > hi) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_for(input int want, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (status != 3'(want) && n < 2000);
    endtask

    task automatic back_to_normal();
        int n;
        desel = 0; batt = 0; ce_n = 1; oe_n = 1; we_n = 1;
        wait_for(0, n);
    endtask

    task automatic t_reset();
        int n;
        check("R1 reset status", status, 4);
        check("R1 reset protect", prot, 1);
        @(negedge clk);
        rst_n = 1'b1;
        wait_for(0, n);
        check("R1 recovery after reset", n, ER);
        check("R1 protect released", prot, 0);
    endtask

    task automatic t_glitch();
        desel = 1;
        repeat (DB - 1) @(negedge clk);
        desel = 0;
        repeat (3 * DB) @(negedge clk);
        check("R2 glitch status", status, 0);
        check("R2 glitch protect", prot, 0);
    endtask

    task automatic t_idle_fail();
        int n;
        desel = 1;
        wait_for(2, n);
        check_rng("R3 idle latency", n, DB + 2, DB + 3);
        check("R3 protect", prot, 1);
        ce_n = 0; oe_n = 0; we_n = 0;
        @(negedge clk);
        check("R6 ce gated", mce_n, 1);
        check("R6 we gated", mwe_n, 1);
        check("R6 oe gated", moe_n, 1);
        we_n = 1;
        @(negedge clk);
        check("R6 drive off", drv, 0);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic t_battery();
        int n;
        batt = 1;
        wait_for(3, n);
        check_rng("R7 battery latency", n, DB + 2, DB + 3);
        check("R7 battery_sel on", bsel, 1);
        check("R7 protect in battery", prot, 1);
        batt = 0;
        wait_for(2, n);
        check_rng("R7 battery exit latency", n, DB + 2, DB + 3);
        check("R7 battery_sel off", bsel, 0);
    endtask

    task automatic t_recover_restart();
        int n;
        desel = 0;
        wait_for(4, n);
        check_rng("R9 recover entry", n, DB + 2, DB + 3);
        repeat (ER / 2) @(negedge clk);
        check("R9 still recovering", status, 4);
        desel = 1;
        wait_for(2, n);
        check_rng("R9 back to protected", n, DB + 2, DB + 3);
        desel = 0;
        wait_for(4, n);
        wait_for(0, n);
        check("R9 full recovery length", n, ER);
    endtask

    task automatic t_pending_end();
        int n;
        ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        check("R10 normal drive", drv, 1);
        desel = 1;
        wait_for(1, n);
        check_rng("R4 pending latency", n, DB + 2, DB + 3);
        repeat (5) @(negedge clk);
        check("R4 still pending", status, 1);
        check("R4 ce passes", mce_n, 0);
        check("R4 protect low", prot, 0);
        ce_n = 1; oe_n = 1;
        wait_for(2, n);
        check("R4 protect after access", n, 1);
        back_to_normal();
    endtask

    task automatic t_pending_overrun();
        int n;
        ce_n = 0; we_n = 0;
        desel = 1;
        wait_for(1, n);
        wait_for(2, n);
        check("R5 window length", n, WP);
        check("R6 we gated on overrun", mwe_n, 1);
        back_to_normal();
    endtask

    task automatic t_pending_batt();
        int n;
        ce_n = 0;
        desel = 1;
        wait_for(1, n);
        batt = 1;
        wait_for(3, n);
        check_rng("R8 fast battery", n, DB + 2, DB + 3);
        check("R8 protect", prot, 1);
        back_to_normal();
        check("R1 normal again", status, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_glitch();
        t_idle_fail();
        t_battery();
        t_recover_restart();
        t_pending_end();
        t_pending_overrun();
        t_pending_batt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule